// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a two-port shared memory and turns accesses to two reserved words into interrupts between the ports. The two top addresses of the space act as mailboxes: the one just below the top belongs to the left port, and the very top one belongs to the right port. When one port writes the other port's mailbox, the other port's interrupt line is pulled low. The owner clears its own interrupt by reading its mailbox.

The mailbox words stay ordinary memory locations that hold 8-bit user data. The memory and its data path live outside this block. The unit only watches the control strobes, addresses and busy lines of both ports. Every strobe, enable, busy and interrupt line is active low. All decisions are taken on the rising edge of a single clock, and each interrupt flag is a register that drives its output directly.

A port whose busy line is low has lost arbitration for the current cycle. None of its accesses can set or clear a flag in that cycle.

Top module: `mbox_irq_unit`

## Requirements
- R1: While `rst` is high, both `l_irq_n` and `r_irq_n` are driven high (inactive) from the next clock edge on.
- R2: A right-port write drives `l_irq_n` low after the sampling edge. A write means `r_cs_n`=0 and `r_we_n`=0, with `r_addr` equal to the left mailbox (all ones except bit 0, 0x7FFE at the default width) and `r_busy_n`=1.
- R3: When `l_cs_n`=0, `l_oe_n`=0, `l_addr` is the left mailbox and `l_busy_n`=1, `l_irq_n` returns high after the edge, whatever the level of `l_we_n`.
- R4: A left-port write (`l_cs_n`=0, `l_we_n`=0) to the right mailbox (all ones, 0x7FFF) with `l_busy_n`=1 drives `r_irq_n` low after the edge.
- R5: When `r_cs_n`=0, `r_oe_n`=0, `r_addr` is the right mailbox and `r_busy_n`=1, `r_irq_n` returns high after the edge, whatever the level of `r_we_n`.
- R6: A write that would set a flag has no effect while the writing port's busy line is low.
- R7: A read that would clear a flag has no effect while the reading port's busy line is low.
- R8: When a set and a clear of the same flag are sampled at the same edge, the flag ends low (the set wins).
- R9: Each of the following leaves both flags unchanged: a write to any other address, a port writing its own mailbox with its output enable high, and any access with chip enable high.
- R10: With no qualifying set or clear, each flag keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left read/write: 0 write, 1 read |
| l_addr | input | AW | Left address |
| l_busy_n | input | 1 | Left busy indication, active low |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right read/write: 0 write, 1 read |
| r_addr | input | AW | Right address |
| r_busy_n | input | 1 | Right busy indication, active low |
| l_irq_n | output | 1 | Left interrupt, active low, registered |
| r_irq_n | output | 1 | Right interrupt, active low, registered |

## Verification
The set and the clear of a single flag can fall in the same cycle. This happens when one port writes the other's mailbox while the owner reads that same mailbox. The bench provokes this directly for both flags, once with the flag already low and once with it high. The flag must end low in both cases. A long stretch of random strobes, biased toward the two mailbox addresses and toward busy lines going low, then makes the collision happen repeatedly next to suppressed accesses. A behavioural model checks each clock against this rule.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
  } port_strobes_t;
endpackage

// File: rtl/mbox_access_decode.sv
module mbox_access_decode #(
  parameter int AW = 15,
  parameter logic [AW-1:0] OWN_BOX = '0,
  parameter logic [AW-1:0] PEER_BOX = '1
) (
  input  mbox_irq_pkg::port_strobes_t strb,
  input  logic [AW-1:0]               addr,
  output logic                        peer_set,
  output logic                        own_clr
);
  logic selected;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    selected = !strb.cs_n && strb.busy_n;
    hit_own  = (addr == OWN_BOX);
    hit_peer = (addr == PEER_BOX);
    peer_set = selected && !strb.we_n && hit_peer;
    own_clr  = selected && !strb.oe_n && hit_own;
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else if (set_req) begin
      irq_n <= 1'b0;
    end else if (clr_req) begin
      irq_n <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_cs_n,
  input  logic          l_oe_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_n,
  input  logic          r_cs_n,
  input  logic          r_oe_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_n,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  import mbox_irq_pkg::*;

  localparam logic [AW-1:0] BOX_L = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};

  port_strobes_t         strb   [NUM_SIDES];
  logic [AW-1:0]         addr_a [NUM_SIDES];
  logic [NUM_SIDES-1:0]  set_other;
  logic [NUM_SIDES-1:0]  clr_own;
  logic [NUM_SIDES-1:0]  irq_vec;

  always_comb begin
    strb[SIDE_L]   = '{cs_n: l_cs_n, oe_n: l_oe_n, we_n: l_we_n, busy_n: l_busy_n};
    strb[SIDE_R]   = '{cs_n: r_cs_n, oe_n: r_oe_n, we_n: r_we_n, busy_n: r_busy_n};
    addr_a[SIDE_L] = l_addr;
    addr_a[SIDE_R] = r_addr;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [AW-1:0] OWN  = (s == SIDE_L) ? BOX_L : BOX_R;
    localparam logic [AW-1:0] PEER = (s == SIDE_L) ? BOX_R : BOX_L;
    localparam int OTHER = NUM_SIDES - 1 - s;

    mbox_access_decode #(
      .AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)
    ) u_dec (
      .strb    (strb[s]),
      .addr    (addr_a[s]),
      .peer_set(set_other[s]),
      .own_clr (clr_own[s])
    );

    mbox_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_req(set_other[OTHER]),
      .clr_req(clr_own[s]),
      .irq_n  (irq_vec[s])
    );
  end

  assign l_irq_n = irq_vec[SIDE_L];
  assign r_irq_n = irq_vec[SIDE_R];
endmodule

// File: rtl/mbox_irq_unit_chk.sv
module mbox_irq_unit_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          l_cs_n,
  input logic          l_oe_n,
  input logic          l_we_n,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_n,
  input logic          r_cs_n,
  input logic          r_oe_n,
  input logic          r_we_n,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_n,
  input logic          l_irq_n,
  input logic          r_irq_n
);
  logic [AW-1:0] box_l;
  logic [AW-1:0] box_r;
  logic wr_to_l;
  logic wr_to_r;
  logic rd_l;
  logic rd_r;

  always_comb begin
    box_l   = '1;
    box_l[0] = 1'b0;
    box_r   = '1;
    wr_to_l = (r_cs_n == 1'b0) && (r_we_n == 1'b0) && (r_addr == box_l) && r_busy_n;
    wr_to_r = (l_cs_n == 1'b0) && (l_we_n == 1'b0) && (l_addr == box_r) && l_busy_n;
    rd_l    = (l_cs_n == 1'b0) && (l_oe_n == 1'b0) && (l_addr == box_l) && l_busy_n;
    rd_r    = (r_cs_n == 1'b0) && (r_oe_n == 1'b0) && (r_addr == box_r) && r_busy_n;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n)); // R1
  AST_LEFT_SET: assert property (@(posedge clk) disable iff (rst) wr_to_l |=> !l_irq_n); // R2
  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (rst) (rd_l && !wr_to_l) |=> l_irq_n); // R3
  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (rst) wr_to_r |=> !r_irq_n); // R4
  AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (rst) (rd_r && !wr_to_r) |=> r_irq_n); // R5
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (rst) (!wr_to_l && !rd_l) |=> $stable(l_irq_n)); // R10
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (rst) (!wr_to_r && !rd_r) |=> $stable(r_irq_n)); // R10
endmodule

bind mbox_irq_unit mbox_irq_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
  .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbox_irq_unit_test.sv
module mbox_irq_unit_test;
  localparam int AW = 15;
  localparam int LBOX = (1 << AW) - 2;
  localparam int RBOX = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_cs_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_busy_n = 1'b1;
  logic r_cs_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_busy_n = 1'b1;
  logic [AW-1:0] l_addr = '0;
  logic [AW-1:0] r_addr = '0;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails = 0;
  int exp_l = 1;
  int exp_r = 1;
  bit done = 0;

  mbox_irq_unit #(.AW(AW)) uut (
    .clk(clk), .rst(rst),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  always #5 clk = ~clk;

  task automatic drive_l(input bit cs, input bit oe, input bit we, input int a, input bit bz);
    l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_addr = a[AW-1:0]; l_busy_n = bz;
  endtask

  task automatic drive_r(input bit cs, input bit oe, input bit we, input int a, input bit bz);
    r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_addr = a[AW-1:0]; r_busy_n = bz;
  endtask

  task automatic idle();
    drive_l(1, 1, 1, 0, 1);
    drive_r(1, 1, 1, 0, 1);
  endtask

  // One clock: update the behavioural model from the applied inputs, then compare.
  task automatic tick(input string tag);
    bit set_l, clr_l, set_r, clr_r;
    @(posedge clk);
    if (rst) begin
      exp_l = 1; exp_r = 1;
    end else begin
      set_l = !r_cs_n && !r_we_n && (int'(r_addr) == LBOX) && r_busy_n;
      clr_l = !l_cs_n && !l_oe_n && (int'(l_addr) == LBOX) && l_busy_n;
      set_r = !l_cs_n && !l_we_n && (int'(l_addr) == RBOX) && l_busy_n;
      clr_r = !r_cs_n && !r_oe_n && (int'(r_addr) == RBOX) && r_busy_n;
      if (set_l) exp_l = 0; else if (clr_l) exp_l = 1;
      if (set_r) exp_r = 0; else if (clr_r) exp_r = 1;
    end
    #2;
    checks++;
    if (int'(l_irq_n) != exp_l || int'(r_irq_n) != exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n actual=%0b expected=%0d, r_irq_n actual=%0b expected=%0d",
               tag, l_irq_n, exp_l, r_irq_n, exp_r);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    idle();
    repeat (3) tick("R1 reset");
    rst = 1'b0;
    tick("R1 after reset");
    // R2: right writes left mailbox
    drive_r(0, 1, 0, LBOX, 1); tick("R2 set left");
    idle(); repeat (3) tick("R10 hold low");
    // R3: left reads its mailbox with we low (ignored), clears
    drive_l(0, 0, 0, LBOX, 1); tick("R3 clear left we=0");
    idle(); tick("R10 hold high");
    drive_r(0, 1, 0, LBOX, 1); tick("R2 set again");
    drive_r(1, 1, 1, 0, 1);
    drive_l(0, 0, 1, LBOX, 1); tick("R3 clear left we=1");
    idle();
    // R4/R5
    drive_l(0, 1, 0, RBOX, 1); tick("R4 set right");
    idle(); tick("R10 right hold");
    drive_r(0, 0, 1, RBOX, 1); tick("R5 clear right");
    idle();
    // R6: busy suppresses set
    drive_r(0, 1, 0, LBOX, 0); tick("R6 busy right blocks set");
    drive_r(1, 1, 1, 0, 1);
    drive_l(0, 1, 0, RBOX, 0); tick("R6 busy left blocks set");
    // R7: busy suppresses clear
    drive_l(0, 1, 0, RBOX, 1); drive_r(0, 1, 0, LBOX, 1); tick("R2 R4 set both");
    drive_l(0, 0, 1, LBOX, 0); drive_r(0, 0, 1, RBOX, 0); tick("R7 busy blocks clears");
    // R9: no-effect accesses
    idle(); drive_l(0, 0, 1, LBOX, 1); drive_r(0, 0, 1, RBOX, 1); tick("R3 R5 clear both");
    drive_l(0, 1, 0, LBOX - 1, 1); drive_r(0, 1, 0, 5, 1); tick("R9 other address");
    drive_l(0, 1, 0, LBOX, 1); drive_r(0, 1, 0, RBOX, 1); tick("R9 own box write oe high");
    drive_l(1, 0, 0, RBOX, 1); drive_r(1, 0, 0, LBOX, 1); tick("R9 cs high");
    // R8: set and clear same cycle, flag high and flag low
    drive_l(0, 0, 1, LBOX, 1); drive_r(0, 1, 0, LBOX, 1); tick("R8 collide left from high");
    tick("R8 collide left from low");
    drive_r(0, 0, 1, RBOX, 1); drive_l(0, 1, 0, RBOX, 1); tick("R8 collide right from high");
    tick("R8 collide right from low");
    idle(); tick("R10 idle");
    // mid-run reset
    rst = 1'b1; tick("R1 mid reset");
    rst = 1'b0; tick("R1 released");
    // random mix biased toward the mailboxes
    for (int i = 0; i < 4000; i++) begin
      int sel;
      int al, ar;
      sel = $urandom_range(0, 3);
      al = (sel == 0) ? LBOX : (sel == 1) ? RBOX : $urandom_range(0, RBOX);
      sel = $urandom_range(0, 3);
      ar = (sel == 0) ? LBOX : (sel == 1) ? RBOX : $urandom_range(0, RBOX);
      drive_l($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1), al,
              $urandom_range(0, 3) != 0);
      drive_r($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1), ar,
              $urandom_range(0, 3) != 0);
      tick("R8 R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule